// File: doc/BRIEF.md
# Phase-Accumulator Sine Generator

This block turns one system clock into a stream of signed sine samples whose frequency is set by a tuning word. On every clock a phase accumulator of `ACC_W` bits adds the tuning word and wraps modulo 2^ACC_W. The seven most significant accumulator bits form a phase index into a full-period, 128-point sine table. The table yields a signed 8-bit sample.

The output frequency is f_clk × tune_word / 2^ACC_W. A wider accumulator lowers the smallest reachable frequency. The table stays the same size, because only the top seven phase bits ever reach it. For example, a 10-bit accumulator gives a lowest frequency eight times below that of a 7-bit one.

The tuning word can come from static switches or from any register. The phase index is available as an output. The sample follows one clock after it.

Top module: `dds_sine_gen`

## Requirements
- R1: While `rst_n` is high, every rising clock edge adds `tune_word` to the accumulator, modulo 2^ACC_W.
- R2: `phase_idx` always equals accumulator bits [ACC_W-1:ACC_W-7].
- R3: For a table index k, `sample` is 127·sin(2πk/128) truncated toward zero, in 8-bit two's complement. The code 0x80 never appears.
- R4: Index 0 gives 0, index 32 gives +127 (0x7F), index 64 gives 0 and index 96 gives -127 (0x81).
- R5: `sample` is the table value of the `phase_idx` present one clock earlier, so there is one cycle of latency.
- R6: The table entry at index k+64 is the two's-complement negation of the entry at index k, for every k in 0..63. For example, index 1 gives +6 and index 65 gives -6 (0xFA).
- R7: `rst_n` is active low and synchronous. A clock edge with `rst_n` low clears the accumulator and the registered index. Right after that edge, `phase_idx` is 0 and `sample` is 0.
- R8: A tuning word of zero holds `phase_idx` and `sample` constant.
- R9: A new tuning word is used from the next clock edge. The accumulator continues from its current value, so the phase does not jump.
- R10: With a power-of-two tuning word w, `phase_idx` wraps from high to low once every 2^ACC_W / w clocks. The smallest word, 1, gives a period of 2^ACC_W clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word | input | ACC_W | Phase increment added on every clock |
| phase_idx | output | 7 | Top seven accumulator bits (current table address) |
| sample | output | 8 | Signed sine sample for the index of the previous clock |

## Verification
The hardest condition to reach from the ports is the tuning word changing while the accumulator is partway through a period. The low accumulator bits that carry the residue cannot be seen at the outputs. The bench therefore runs a reference accumulator beside the design. It switches between odd, large and zero tuning words in mid-run, and it compares every phase index and sample against the reference, so a lost or reset residue appears as a wrong phase a few clocks later. Whole-period sweeps with an increment of one table step per clock hit every table entry, including the four landmark indices and both halves of the symmetric table.

// File: rtl/dds_sine_pkg.sv
// Package: dds_sine_pkg
// Shared widths, types and the quarter-wave magnitude table for the
// phase-accumulator sine generator. Assumes a fixed 128-point, 8-bit table.
package dds_sine_pkg;

    localparam int IDX_W   = 7;                // table address width
    localparam int SAMP_W  = 8;                // sample width
    localparam int QTR_W   = IDX_W - 1;        // index width inside one half
    localparam int QTR_TOP = 1 << (QTR_W - 1); // quarter-wave peak index (32)

    typedef logic [IDX_W-1:0]  phase_idx_t;
    typedef logic [SAMP_W-1:0] sample_t;
    typedef logic [QTR_W-1:0]  half_idx_t;

    // Magnitude of 127*sin(2*pi*q/128) truncated toward zero, q = 0..32.
    function automatic sample_t quarter_mag(input half_idx_t q);
        sample_t m;
        case (q)
            6'd0:  m = 8'd0;    6'd1:  m = 8'd6;    6'd2:  m = 8'd12;
            6'd3:  m = 8'd18;   6'd4:  m = 8'd24;   6'd5:  m = 8'd30;
            6'd6:  m = 8'd36;   6'd7:  m = 8'd42;   6'd8:  m = 8'd48;
            6'd9:  m = 8'd54;   6'd10: m = 8'd59;   6'd11: m = 8'd65;
            6'd12: m = 8'd70;   6'd13: m = 8'd75;   6'd14: m = 8'd80;
            6'd15: m = 8'd85;   6'd16: m = 8'd89;   6'd17: m = 8'd94;
            6'd18: m = 8'd98;   6'd19: m = 8'd102;  6'd20: m = 8'd105;
            6'd21: m = 8'd108;  6'd22: m = 8'd112;  6'd23: m = 8'd114;
            6'd24: m = 8'd117;  6'd25: m = 8'd119;  6'd26: m = 8'd121;
            6'd27: m = 8'd123;  6'd28: m = 8'd124;  6'd29: m = 8'd125;
            6'd30: m = 8'd126;  6'd31: m = 8'd126;  6'd32: m = 8'd127;
            default: m = 8'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Phase accumulator: adds the tuning word on every clock, wraps modulo
// 2^ACC_W, and exposes only the top IDX_W bits as the table index.
// Assumes ACC_W >= IDX_W and a synchronous active-low reset.
module dds_phase_acc
    import dds_sine_pkg::*;
#(
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune_word,
    output phase_idx_t       idx_o
);

    logic [ACC_W-1:0] acc_q;

    // Accumulate the tuning word; wrap is the natural overflow of ACC_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + tune_word;
    end

    // Truncate the phase to the table address.
    assign idx_o = acc_q[ACC_W-1 -: IDX_W];

    // R1: the step between consecutive phases is the previous tuning word.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ACC_W'(acc_q - $past(acc_q)) == $past(tune_word)));

    // R8: a zero tuning word freezes the phase.
    assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(tune_word) == '0)) |-> $stable(acc_q));

endmodule

// File: rtl/dds_addr_reg.sv
// Module: dds_addr_reg
// Registers the table index so that the table sits after a flop. This
// gives one clock from phase to sample. Assumes a synchronous active-low reset.
module dds_addr_reg
    import dds_sine_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_idx_t idx_i,
    output phase_idx_t idx_q
);

    logic past_valid;

    // Hold the index for one clock ahead of the table.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_i;
    end

    // Marks that at least one edge has passed (used only by the checks).
    always_ff @(posedge clk) past_valid <= 1'b1;

    // R7: a clock edge with reset low leaves the registered index at zero.
    assert_reset_clear_R7: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (idx_q == '0));

endmodule

// File: rtl/dds_sine_lut.sv
// Module: dds_sine_lut
// Combinational full-period sine table, 128 points by 8 bits. Only one
// quarter is stored; the index is folded about the peak and the sign is
// taken from the half-period bit.
module dds_sine_lut
    import dds_sine_pkg::*;
(
    input  phase_idx_t idx_i,
    output sample_t    sample_o
);

    logic      neg_half;
    half_idx_t in_half;
    half_idx_t folded;
    sample_t   mag;

    // Fold the index into the first quarter and look up the magnitude.
    always_comb begin
        neg_half = idx_i[IDX_W-1];
        in_half  = idx_i[QTR_W-1:0];
        folded   = (in_half > half_idx_t'(QTR_TOP)) ? (half_idx_t'(0) - in_half) : in_half;
        mag      = quarter_mag(folded);
        sample_o = neg_half ? (sample_t'(0) - mag) : mag;
    end

    // R3: the most negative code is never produced.
    always_comb begin
        assert_no_min_code_R3: assert (sample_o != 8'h80);
    end

endmodule

// File: rtl/dds_sine_gen.sv
// Module: dds_sine_gen (top)
// Phase-accumulator sine generator: accumulator -> registered 7-bit index
// -> 128-point signed table. phase_idx is the current index and sample is
// the table value of the previous one. ACC_W sets the frequency resolution.
module dds_sine_gen
    import dds_sine_pkg::*;
#(
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune_word,
    output logic [6:0]       phase_idx,
    output logic [7:0]       sample
);

    phase_idx_t cur_idx;
    phase_idx_t reg_idx;
    sample_t    lut_out;

    // Phase generation.
    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .idx_o     (cur_idx)
    );

    // Address register ahead of the table.
    dds_addr_reg u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_i (cur_idx),
        .idx_q (reg_idx)
    );

    // Sine table.
    dds_sine_lut u_lut (
        .idx_i    (reg_idx),
        .sample_o (lut_out)
    );

    assign phase_idx = cur_idx;
    assign sample    = lut_out;

    // R5: the table is addressed by the index shown one clock earlier.
    assert_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (reg_idx == $past(phase_idx)));

    // R4: the quarter-period index produces the positive peak.
    assert_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 7'd32) |-> (sample == 8'h7F));

    // R4: the three-quarter index produces the negative peak.
    assert_trough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 7'd96) |-> (sample == 8'h81));

endmodule

// File: tb/test_dds_sine_gen.sv
`timescale 1ns/1ps
module test_dds_sine_gen;

    localparam int ACC_W = 10;
    localparam int FULL  = 1 << ACC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] tune_word = '0;
    logic [6:0]       phase_idx;
    logic [7:0]       sample;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    logic [ACC_W-1:0] ref_acc = '0;
    logic [6:0]       ref_prev_idx = '0;
    int               obs [128];

    dds_sine_gen #(.ACC_W(ACC_W)) i_dds_sine_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase_idx (phase_idx),
        .sample    (sample)
    );

    always #4 clk = ~clk;

    // Reference accumulator built from R1 and R7.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_acc      <= '0;
            ref_prev_idx <= '0;
        end else begin
            ref_acc      <= ref_acc + tune_word;
            ref_prev_idx <= ref_acc[ACC_W-1 -: 7];
        end
    end

    // Expected sample from the R3 formula (truncation toward zero, signed).
    function automatic int sine_ref(input int k);
        int  m = k % 64;
        int  q = (m <= 32) ? m : 64 - m;
        real v = 127.0 * $sin(2.0 * 3.14159265358979 * q / 128.0);
        int  mag = $rtoi(v + 1.0e-6);
        return (k >= 64) ? -mag : mag;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock, then compare both outputs with the reference (R2, R3, R5).
    task automatic step_and_compare();
        @(negedge clk);
        check("R2 phase index", int'(phase_idx), int'(ref_acc[ACC_W-1 -: 7]));
        check("R5 sample lag", int'($signed(sample)), sine_ref(int'(ref_prev_idx)));
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tune_word = 10'd77;
        @(negedge clk);
        check("R7 reset phase", int'(phase_idx), 0);
        check("R7 reset sample", int'($signed(sample)), 0);
        rst_n = 1'b1;
    endtask

    // tune_word = 8 moves one table entry per clock: whole-table sweep (R3 R4 R6).
    task automatic test_table_sweep();
        tune_word = 10'd8;
        for (int c = 0; c < 130; c++) begin
            step_and_compare();
            obs[int'(ref_prev_idx)] = int'($signed(sample));
        end
        check("R4 index 0",  obs[0],  0);
        check("R4 index 32", obs[32], 127);
        check("R4 index 64", obs[64], 0);
        check("R4 index 96", obs[96], -127);
        check("R6 index 1",  obs[1],  6);
        check("R6 index 65", obs[65], -6);
        for (int k = 0; k < 64; k++) begin
            check("R6 symmetry", obs[k + 64], -obs[k]);
            check("R3 formula", obs[k], sine_ref(k));
        end
    endtask

    task automatic test_zero_hold();
        logic [6:0] held_idx;
        logic [7:0] held_samp;
        tune_word = 10'd37;
        for (int c = 0; c < 9; c++) step_and_compare();
        tune_word = '0;
        step_and_compare();
        step_and_compare();
        held_idx  = phase_idx;
        held_samp = sample;
        for (int c = 0; c < 20; c++) begin
            step_and_compare();
            check("R8 phase held", int'(phase_idx), int'(held_idx));
            check("R8 sample held", int'(sample), int'(held_samp));
        end
    endtask

    // Odd residue kept across tuning changes (R1, R9).
    task automatic test_retune();
        tune_word = 10'd37;
        for (int c = 0; c < 13; c++) step_and_compare();
        tune_word = 10'd613;
        for (int c = 0; c < 11; c++) step_and_compare();
        tune_word = 10'd5;
        for (int c = 0; c < 40; c++) step_and_compare();
        tune_word = 10'd1023;
        for (int c = 0; c < 30; c++) begin
            step_and_compare();
            check("R9 continuity", int'(phase_idx), int'(ref_acc[ACC_W-1 -: 7]));
        end
    endtask

    // Count clocks between successive high-to-low wraps of phase_idx (R10).
    task automatic test_period(input int word, input int exp_period);
        logic [6:0] prev;
        int         count;
        bit         armed;
        tune_word = ACC_W'(word);
        armed = 1'b0;
        count = 0;
        @(negedge clk);
        prev = phase_idx;
        for (int c = 0; c < 3 * FULL; c++) begin
            @(negedge clk);
            count++;
            if (phase_idx < prev) begin
                if (armed) begin
                    check("R10 wrap period", count, exp_period);
                    break;
                end
                armed = 1'b1;
                count = 0;
            end
            prev = phase_idx;
        end
        if (!armed) check("R10 wrap seen", 0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_table_sweep();
        test_zero_hold();
        test_retune();
        test_reset();
        test_period(1, FULL);
        test_period(8, FULL / 8);
        test_period(64, FULL / 64);
        test_period(512, 2);
        finish_run();
    end

    initial begin
        #(8 * 50000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule